// File: doc/BRIEF.md
# Command Port with Windowed Interrupt Status

This block is the control port that a host processor sees on a network controller. The host writes 16-bit command words. Each word carries a 5-bit opcode in its upper bits and an 11-bit argument in its lower bits. The port decodes the opcode and uses it to select one of eight register windows, to turn the receiver and transmitter on or off, to reset them, to load an interrupt mask or a receive filter, to acknowledge events, or to reset the whole port.

Hardware events arrive as single-cycle pulses and are latched into an 8-bit event field. The event field, the selected window and a busy flag read back together as one 16-bit status word. A single interrupt line is raised whenever a latched event is enabled by the mask. Each accepted command holds the busy flag high for a fixed number of cycles. A global reset holds it high for a longer count. While the flag is high, further command writes are dropped.

Top module: `nic_cmd_ctrl`

## Requirements
- R1: After reset, the status word reads 0, `irq` is low, the receiver and transmitter are disabled and the filter is 0.
- R2: Opcode 1 sets status bits 15-13 to argument bits 2-0, whatever the other argument bits hold. Status bits 11-8 always read 0.
- R3: An accepted command sets status bit 12 (busy) for exactly BUSY_CYC cycles. A global reset (opcode 0) sets it for exactly RST_CYC cycles.
- R4: A command presented while busy is dropped and changes no state.
- R5: Opcode 4 enables the receiver and opcode 3 disables it. Opcode 5 pulses `rx_rst_pulse` for one cycle and disables the receiver. The argument of these opcodes has no effect.
- R6: Opcode 9 enables the transmitter and opcode 10 disables it. Opcode 11 pulses `tx_rst_pulse` for one cycle and disables the transmitter.
- R7: Opcode 16 loads `rx_filter` from argument bits 3-0. Bit 0 is individual, bit 1 multicast, bit 2 broadcast and bit 3 promiscuous.
- R8: A pulse on `evt_in[k]` (k = 1..7) sets status bit k on the next clock edge. The status bits for events are 1 adapter failure, 2 TX complete, 3 TX available, 4 RX complete, 5 RX early, 6 interrupt requested and 7 statistics update.
- R9: Opcode 14 loads the mask from argument bits 7-1. `irq` is high exactly when some status bit k in 1..7 is set while its mask bit k is also set.
- R10: Status bit 0 (the latch) sets on the same edge at which a masked event becomes pending.
- R11: Opcode 13 clears each status bit whose argument bit is set. The latch (bit 0) clears only by acknowledge with argument bit 0 set, or by global reset.
- R12: Opcode 12 sets status bit 6.
- R13: Unknown opcodes (2, 6, 7, 31) are accepted and set busy but change nothing else.
- R14: A global reset clears the window, the enables, the filter, the mask and all event bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_word | input | 16 | Opcode in bits 15-11, argument in bits 10-0 |
| evt_in | input | 7 | Event pulses for status bits 7..1 |
| status | output | 16 | Window, busy flag and event bits |
| irq | output | 1 | Interrupt request |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| rx_rst_pulse | output | 1 | One-cycle receiver reset |
| tx_rst_pulse | output | 1 | One-cycle transmitter reset |
| rx_filter | output | 4 | Receive filter selection |

## Verification
Every command effect is registered. Window, enables, filter, mask, events and busy are therefore all due on the first clock edge after the strobe is seen while idle. The reset pulses are due on that same edge and last one cycle. An event pulse shows in the status word, in the latch and on `irq` on the edge that samples it.

The bench drives each stimulus on a falling edge and samples exactly one falling edge later. It measures busy by counting falling edges while bit 12 stays high. Before each command it waits for idle, so every write is accepted at a known edge. The one exception is the deliberate write made during busy.

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl #(
  parameter int BUSY_CYC = 3,
  parameter int RST_CYC  = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  input  logic [7:1]  evt_in,
  output logic [15:0] status,
  output logic        irq,
  output logic        rx_en,
  output logic        tx_en,
  output logic        rx_rst_pulse,
  output logic        tx_rst_pulse,
  output logic [3:0]  rx_filter
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [4:0] OP_GRST = 5'd0,  OP_WIN = 5'd1,   OP_RXDIS = 5'd3,
                         OP_RXEN = 5'd4,  OP_RXRST = 5'd5, OP_TXEN = 5'd9,
                         OP_TXDIS = 5'd10, OP_TXRST = 5'd11, OP_REQ = 5'd12,
                         OP_ACK = 5'd13,  OP_MASK = 5'd14, OP_FILT = 5'd16;

  logic [CW-1:0] busy_cnt;
  logic [2:0]    win;
  logic [7:1]    mask, mask_nxt, ev_hi_nxt, ev_set;
  logic [7:0]    ev, clr;
  logic          latch_nxt;

  wire [4:0]  op     = cmd_word[15:11];
  wire [10:0] arg    = cmd_word[10:0];
  wire        busy   = busy_cnt != '0;
  wire        accept = cmd_valid && !busy;
  wire        grst   = accept && op == OP_GRST;

  always_comb begin
    ev_set    = evt_in;
    ev_set[6] = evt_in[6] | (accept && op == OP_REQ);
    clr       = (accept && op == OP_ACK) ? arg[7:0] : 8'h00;
    mask_nxt  = (accept && op == OP_MASK) ? arg[7:1] : mask;
    ev_hi_nxt = (ev[7:1] & ~clr[7:1]) | ev_set;
    latch_nxt = (ev[0] & ~clr[0]) | (|(ev_hi_nxt & mask_nxt));
    if (grst) begin
      mask_nxt  = '0;
      ev_hi_nxt = '0;
      latch_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt     <= '0;
      win          <= '0;
      mask         <= '0;
      ev           <= '0;
      rx_en        <= 1'b0;
      tx_en        <= 1'b0;
      rx_rst_pulse <= 1'b0;
      tx_rst_pulse <= 1'b0;
      rx_filter    <= '0;
    end else begin
      rx_rst_pulse <= 1'b0;
      tx_rst_pulse <= 1'b0;
      mask         <= mask_nxt;
      ev           <= {ev_hi_nxt, latch_nxt};
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (accept) begin
        busy_cnt <= CW'(BUSY_CYC);
        case (op)
          OP_GRST: begin
            busy_cnt  <= CW'(RST_CYC);
            win       <= '0;
            rx_en     <= 1'b0;
            tx_en     <= 1'b0;
            rx_filter <= '0;
          end
          OP_WIN:   win <= arg[2:0];
          OP_RXDIS: rx_en <= 1'b0;
          OP_RXEN:  rx_en <= 1'b1;
          OP_RXRST: begin rx_en <= 1'b0; rx_rst_pulse <= 1'b1; end
          OP_TXEN:  tx_en <= 1'b1;
          OP_TXDIS: tx_en <= 1'b0;
          OP_TXRST: begin tx_en <= 1'b0; tx_rst_pulse <= 1'b1; end
          OP_FILT:  rx_filter <= arg[3:0];
          default: ;
        endcase
      end
    end
  end

  assign status = {win, busy, 4'b0000, ev};
  assign irq    = |(ev[7:1] & mask);
endmodule

module nic_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [15:0] cmd_word,
  input logic [15:0] status,
  input logic        irq,
  input logic        rx_en,
  input logic        rx_rst_pulse
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[11:8] == 4'b0000);
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !status[12]) |=> status[12]);
  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[12] |=> $stable(status[15:13]));
  // R5
  rx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_pulse |-> !rx_en);
  // R10
  irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[0]);
  // R11
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(cmd_valid && !status[12] &&
      ((cmd_word[15:11] == 5'd13 && cmd_word[0]) || cmd_word[15:11] == 5'd0)));
endmodule

bind nic_cmd_ctrl nic_cmd_ctrl_chk chk_i (.*);

// File: tb/nic_cmd_ctrl_test.sv
module nic_cmd_ctrl_test;
  localparam int BUSY_CYC = 3;
  localparam int RST_CYC  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [7:1]  evt_in = '0;
  logic [15:0] status;
  logic        irq, rx_en, tx_en, rx_rst_pulse, tx_rst_pulse;
  logic [3:0]  rx_filter;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  nic_cmd_ctrl #(.BUSY_CYC(BUSY_CYC), .RST_CYC(RST_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .evt_in(evt_in), .status(status), .irq(irq), .rx_en(rx_en), .tx_en(tx_en),
    .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse), .rx_filter(rx_filter));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] w(input int op, input int arg);
    return {op[4:0], arg[10:0]};
  endfunction

  task automatic send(input logic [15:0] word);
    @(negedge clk);
    while (status[12]) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = word;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (status[12] && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    int n;
    logic [15:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(status == 16'h0, "R1 status", status, 0);
    chk(!irq && !rx_en && !tx_en && rx_filter == 0, "R1 outputs",
        {irq, rx_en, tx_en, rx_filter}, 0);

    // R2: window sweep with junk upper argument bits
    for (int k = 0; k < 8; k++) begin
      send(w(1, 11'h5F8 | k));
      chk(status[15:13] == k[2:0], "R2 window", status[15:13], k);
      chk(status[11:8] == 0, "R2 reserved", status[11:8], 0);
    end

    // R3: busy length
    send(w(4, 0));
    busy_len(n);
    chk(n == BUSY_CYC, "R3 busy", n, BUSY_CYC);

    // R4: command while busy is dropped
    send(w(1, 5));
    cmd_valid = 1'b1; cmd_word = w(1, 2);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_len(n);
    chk(status[15:13] == 3'd5, "R4 dropped", status[15:13], 5);

    // R5: receiver
    send(w(3, 11'h7FF));
    chk(!rx_en, "R5 rx disable", rx_en, 0);
    send(w(4, 11'h2A5));
    chk(rx_en, "R5 rx enable", rx_en, 1);
    send(w(5, 11'h3C3));
    chk(rx_rst_pulse && !rx_en, "R5 rx reset", {rx_rst_pulse, rx_en}, 2);
    @(negedge clk);
    chk(!rx_rst_pulse, "R5 rx pulse width", rx_rst_pulse, 0);

    // R6: transmitter
    send(w(9, 11'h155));
    chk(tx_en, "R6 tx enable", tx_en, 1);
    send(w(10, 0));
    chk(!tx_en, "R6 tx disable", tx_en, 0);
    send(w(9, 0));
    send(w(11, 11'h7FF));
    chk(tx_rst_pulse && !tx_en, "R6 tx reset", {tx_rst_pulse, tx_en}, 2);
    @(negedge clk);
    chk(!tx_rst_pulse, "R6 tx pulse width", tx_rst_pulse, 0);

    // R7: filter sweep
    for (int f = 0; f < 16; f++) begin
      send(w(16, 11'h7F0 | f));
      chk(rx_filter == f[3:0], "R7 filter", rx_filter, f);
    end

    // R8 R9 R10 R11: mask x event sweep
    for (int i = 1; i < 8; i++) begin
      send(w(14, 1 << i));
      send(w(13, 8'hFF));
      chk(status[7:0] == 0 && !irq, "R11 ack all", status[7:0], 0);
      for (int j = 1; j < 8; j++) begin
        @(negedge clk);
        evt_in = 7'(1 << (j - 1)) << 0;
        evt_in = '0; evt_in[j] = 1'b1;
        @(negedge clk);
        evt_in = '0;
        chk(status[j], "R8 event set", status[7:0], 1 << j);
        chk(irq == (i == j), "R9 irq", irq, i == j);
        chk(status[0] == (i == j), "R10 latch", status[0], i == j);
        send(w(13, 1 << j));
        chk(!status[j] && !irq, "R11 event ack", {status[j], irq}, 0);
        chk(status[0] == (i == j), "R11 latch held", status[0], i == j);
        send(w(13, 1));
        chk(status[7:0] == 0, "R11 latch ack", status[7:0], 0);
      end
    end

    // R12: request interrupt
    send(w(14, 8'h40));
    send(w(12, 11'h7FF));
    chk(status[6] && status[0] && irq, "R12 request", status[7:0], 8'h41);
    send(w(13, 8'hFF));

    // R13: unknown opcodes
    send(w(4, 0));
    send(w(16, 5));
    send(w(1, 3));
    foreach (snap[b]) ;
    begin
      int unk[4] = '{2, 6, 7, 31};
      foreach (unk[u]) begin
        snap = status;
        send(w(unk[u], 11'h7FF));
        chk(status[12], "R13 busy", status[12], 1);
        chk(status[15:13] == snap[15:13] && status[7:0] == snap[7:0] &&
            rx_en && rx_filter == 4'd5, "R13 no effect", status, snap);
      end
    end

    // R14 and R3: global reset
    send(w(9, 0));
    send(w(14, 8'hFE));
    evt_in = 7'h7F;
    @(negedge clk);
    evt_in = '0;
    send(w(0, 11'h7FF));
    busy_len(n);
    chk(n == RST_CYC, "R3 reset busy", n, RST_CYC);
    chk(status == 16'h0 && !irq, "R14 status", status, 0);
    chk(!rx_en && !tx_en && rx_filter == 0, "R14 outputs",
        {rx_en, tx_en, rx_filter}, 0);
    @(negedge clk);
    evt_in = '0; evt_in[3] = 1'b1;
    @(negedge clk);
    evt_in = '0;
    chk(!irq && !status[0], "R14 mask cleared", {irq, status[0]}, 0);

    finish_up();
  end
endmodule